// File: doc/BRIEF.md
# Slow-Lane Long-Latency Instruction Queue

This block sits between a small pseudo-ROB stage and the main issue queue. Every instruction that leaves the pseudo-ROB is routed by the block. Instructions that wait on a missed load are diverted into a secondary in-order queue. All other instructions pass straight on to the main issue queue. A 32-entry bit vector, with one bit per logical register, records which registers will be written by long-latency work. Each instruction may name two sources and one destination, and each of the three carries its own enable.

A load flagged as a cache miss always goes to the slow queue, and it marks its destination as long-latency. A non-miss instruction that reads a marked register follows it into the slow queue and marks its own destination. An instruction that reads no marked register goes to the main queue and unmarks its destination.

When a load completes and its tag equals that of the load at the head of the slow queue, that load is released. On the following cycles the head of the queue is re-inserted into the main issue queue. Up to four entries go per cycle, in queue order, and the group stops in front of any later load that is still waiting. Once the slow queue has drained empty, the whole vector is cleared.

Every data stream uses valid/ready. The incoming instruction stream is held off only when its instruction is headed for a full slow queue, or is headed for the main queue while the main queue is not ready. The main-queue output is combinational from the input. The re-insertion stream is all-or-nothing: when `reins_ready` is high, every lane whose valid bit is shown is taken in that cycle. When it is low, nothing is taken and the lanes hold their contents.

Top module: `slow_lane_queue`

## Requirements
- R1: After reset the slow queue is empty, the vector is clear, `reins_valid` is 0, `main_valid` follows `in_valid`, and `in_ready` follows `main_ready`.
- R2: An instruction with `in_miss`=1 is a long-latency load. It is always sent to the slow queue (`main_valid`=0), is stored as a load entry, and sets the vector bit of its destination when it is accepted.
- R3: A non-miss instruction goes to the slow queue when an enabled source has its vector bit set. On acceptance it sets the bit of its enabled destination.
- R4: Every other instruction is sent to the main queue, with `main_valid`=`in_valid` and `main_tag`=`in_tag`. On acceptance it clears the bit of its enabled destination.
- R5: The slow queue holds 64 entries. When it is full, `in_ready` is 0 for any instruction bound for it, and nothing is enqueued.
- R6: A completion releases the head entry when all of the following hold: `cpl_valid`=1, the head entry is a load, `cpl_tag` equals its tag, and the head is not being removed in that same cycle. Re-insertion lanes become valid from the next cycle. Any other completion has no effect.
- R7: Lane 0 of the re-insertion stream is the queue head. It is valid when the queue is non-empty and the head is either not a load or is a released load. Lane k (k=1..3) is valid when lane k-1 is valid and entry k exists and is not a load. Lane k carries its tag on `reins_tag[k*6 +: 6]`, in queue order.
- R8: When `reins_ready`=0 no entry is removed and lane 0 keeps its tag. When `reins_ready`=1 all valid lanes are removed in that cycle.
- R9: When a cycle leaves the slow queue empty, every vector bit is cleared. After that, a reader of a previously marked register goes to the main queue.
- R10: For a main-bound instruction, `in_ready` equals `main_ready`, and the instruction is accepted only when both `in_valid` and `main_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction from the pseudo-ROB is valid |
| in_ready | output | 1 | Instruction is accepted this cycle when also valid |
| in_tag | input | 6 | Instruction identifier |
| in_miss | input | 1 | Instruction is a load that missed in the cache |
| in_src0_en | input | 1 | First source operand present |
| in_src0 | input | 5 | First source logical register |
| in_src1_en | input | 1 | Second source operand present |
| in_src1 | input | 5 | Second source logical register |
| in_dst_en | input | 1 | Destination present |
| in_dst | input | 5 | Destination logical register |
| main_valid | output | 1 | Instruction offered to the main issue queue |
| main_ready | input | 1 | Main issue queue accepts the direct path |
| main_tag | output | 6 | Tag offered to the main issue queue |
| cpl_valid | input | 1 | A load completed |
| cpl_tag | input | 6 | Tag of the completed load |
| reins_valid | output | 4 | Per-lane valid bits of the re-insertion group |
| reins_ready | input | 1 | Main issue queue takes the whole shown group |
| reins_tag | output | 24 | Lane tags, lane k at bits k*6 upward |

## Verification
The routing outputs (`main_valid`, `main_tag`, `in_ready`) and the re-insertion lanes are combinational from registered state, so they are due in the same cycle the stimulus is applied. The bench drives inputs after a rising edge and compares them a little after the falling edge of that cycle. A completion, an enqueue or a removal shows up one edge later: the bench model updates its queue, vector and release flag at that rising edge and compares the new lane contents at the next falling edge. Because of this, a release is first seen as lane 0 turning valid in the cycle after the matching completion.

// File: rtl/slq_pkg.sv
package slq_pkg;
  localparam int NUM_LREG = 32;
  localparam int LREG_W   = $clog2(NUM_LREG);
  typedef logic [LREG_W-1:0] lreg_t;
endpackage

// File: rtl/slq_depvec.sv
// Long-latency mark per logical register.
module slq_depvec
  import slq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                q0_en,
  input  lreg_t               q0,
  input  logic                q1_en,
  input  lreg_t               q1,
  output logic                hit,
  input  logic                upd_en,
  input  lreg_t               upd_idx,
  input  logic                upd_val,
  input  logic                clr_all,
  output logic [NUM_LREG-1:0] vec
);
  assign hit = (q0_en & vec[q0]) | (q1_en & vec[q1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec <= '0;
    end else if (clr_all) begin
      vec <= '0;
    end else if (upd_en) begin
      vec[upd_idx] <= upd_val;
    end
  end
endmodule

// File: rtl/slq_fifo.sv
// In-order store with single push and multi-entry pop; DEPTH must be a power of two.
module slq_fifo #(
  parameter int DEPTH = 64,
  parameter int EW    = 7,
  parameter int LANES = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [EW-1:0]       push_data,
  input  logic [PW-1:0]       pop_n,
  output logic [CW-1:0]       count,
  output logic                empty_next,
  output logic [LANES*EW-1:0] peek
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic [CW-1:0] count_d;

  assign count_d    = count + CW'(push) - CW'(pop_n);
  assign empty_next = (count_d == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    assign peek[k*EW +: EW] = mem[head + AW'(k)];
  end

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head + AW'(pop_n);
      tail  <= tail + AW'(push);
      count <= count_d;
    end
  end
endmodule

// File: rtl/slq_drain.sv
// Release flag and re-insertion lane selection.
module slq_drain #(
  parameter int LANES = 4,
  parameter int TAG_W = 6,
  parameter int CW    = 7,
  localparam int EW   = TAG_W + 1,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       count,
  input  logic [LANES*EW-1:0] peek,
  input  logic                cpl_valid,
  input  logic [TAG_W-1:0]    cpl_tag,
  input  logic                reins_ready,
  output logic [LANES-1:0]    lane_v,
  output logic [PW-1:0]       pop_n,
  output logic                rel_q
);
  logic head_ld, head_pop, match;

  // entry layout: {is_load, tag}
  assign head_ld = peek[EW-1];
  assign lane_v[0] = (count != '0) && (!head_ld || rel_q);

  for (genvar k = 1; k < LANES; k++) begin : g_lane
    assign lane_v[k] = lane_v[k-1] && (count > CW'(k)) && !peek[k*EW + EW - 1];
  end

  assign pop_n    = reins_ready ? PW'($countones(lane_v)) : '0;
  assign head_pop = reins_ready && lane_v[0];
  assign match    = cpl_valid && (count != '0) && head_ld && (peek[TAG_W-1:0] == cpl_tag);

  always_ff @(posedge clk) begin
    if (!rst_n)        rel_q <= 1'b0;
    else if (head_pop) rel_q <= 1'b0;
    else if (match)    rel_q <= 1'b1;
  end
endmodule

// File: rtl/slow_lane_queue.sv
module slow_lane_queue
  import slq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int TAG_W = 6,
  localparam int EW   = TAG_W + 1,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [TAG_W-1:0]       in_tag,
  input  logic                   in_miss,
  input  logic                   in_src0_en,
  input  logic [LREG_W-1:0]      in_src0,
  input  logic                   in_src1_en,
  input  logic [LREG_W-1:0]      in_src1,
  input  logic                   in_dst_en,
  input  logic [LREG_W-1:0]      in_dst,
  output logic                   main_valid,
  input  logic                   main_ready,
  output logic [TAG_W-1:0]       main_tag,
  input  logic                   cpl_valid,
  input  logic [TAG_W-1:0]       cpl_tag,
  output logic [LANES-1:0]       reins_valid,
  input  logic                   reins_ready,
  output logic [LANES*TAG_W-1:0] reins_tag
);
  logic                  dep_hit, go_slow, fifo_full, accept, push;
  logic [CW-1:0]         count;
  logic                  empty_next, rel_q;
  logic [LANES*EW-1:0]   peek;
  logic [PW-1:0]         pop_n;
  logic [NUM_LREG-1:0]   vec;

  assign go_slow    = in_miss | dep_hit;
  assign fifo_full  = (count == CW'(DEPTH));
  assign in_ready   = go_slow ? !fifo_full : main_ready;
  assign accept     = in_valid & in_ready;
  assign push       = accept & go_slow;
  assign main_valid = in_valid & ~go_slow;
  assign main_tag   = in_tag;

  slq_depvec u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .q0_en   (in_src0_en),
    .q0      (in_src0),
    .q1_en   (in_src1_en),
    .q1      (in_src1),
    .hit     (dep_hit),
    .upd_en  (accept & in_dst_en),
    .upd_idx (in_dst),
    .upd_val (go_slow),
    .clr_all (empty_next),
    .vec     (vec)
  );

  slq_fifo #(.DEPTH(DEPTH), .EW(EW), .LANES(LANES)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_data  ({in_miss, in_tag}),
    .pop_n      (pop_n),
    .count      (count),
    .empty_next (empty_next),
    .peek       (peek)
  );

  slq_drain #(.LANES(LANES), .TAG_W(TAG_W), .CW(CW)) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (count),
    .peek        (peek),
    .cpl_valid   (cpl_valid),
    .cpl_tag     (cpl_tag),
    .reins_ready (reins_ready),
    .lane_v      (reins_valid),
    .pop_n       (pop_n),
    .rel_q       (rel_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_rtag
    assign reins_tag[k*TAG_W +: TAG_W] = peek[k*EW +: TAG_W];
  end
endmodule

// File: rtl/slq_chk.sv
module slq_chk #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int TAG_W = 6,
  parameter int CW    = 7,
  parameter int NV    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_miss,
  input logic                   go_slow,
  input logic                   main_valid,
  input logic [CW-1:0]          count,
  input logic [NV-1:0]          vec,
  input logic [LANES-1:0]       reins_valid,
  input logic                   reins_ready,
  input logic [LANES*TAG_W-1:0] reins_tag
);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && go_slow) |-> !in_ready);

  p_miss_slow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_miss) |-> !main_valid);

  p_empty_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (vec == '0));

  p_hold_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reins_valid[0] && !reins_ready) |=> (reins_valid[0] && $stable(reins_tag[TAG_W-1:0])));

  for (genvar k = 1; k < LANES; k++) begin : g_contig
    p_lane_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reins_valid[k] |-> reins_valid[k-1]);
  end
endmodule

bind slow_lane_queue slq_chk #(
  .DEPTH(DEPTH), .LANES(LANES), .TAG_W(TAG_W), .CW(CW), .NV(slq_pkg::NUM_LREG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_miss     (in_miss),
  .go_slow     (go_slow),
  .main_valid  (main_valid),
  .count       (count),
  .vec         (vec),
  .reins_valid (reins_valid),
  .reins_ready (reins_ready),
  .reins_tag   (reins_tag)
);

// File: tb/slow_lane_queue_tb.sv
module slow_lane_queue_tb;
  localparam int DEPTH = 64;
  localparam int LANES = 4;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_miss = 0, in_src0_en = 0, in_src1_en = 0, in_dst_en = 0;
  logic [4:0] in_src0 = 0, in_src1 = 0, in_dst = 0;
  logic [TAG_W-1:0] in_tag = 0, cpl_tag = 0, main_tag;
  logic in_ready, main_valid, main_ready = 1, cpl_valid = 0, reins_ready = 0;
  logic [LANES-1:0] reins_valid;
  logic [LANES*TAG_W-1:0] reins_tag;

  always #2 clk = ~clk;

  slow_lane_queue u_dut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  logic [TAG_W-1:0] m_tag [DEPTH];
  bit m_ld [DEPTH];
  int m_head = 0, m_cnt = 0;
  logic [31:0] m_vec = '0;
  bit m_rel = 0;
  int ntag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_slow();
    return in_miss || (in_src0_en && m_vec[in_src0]) || (in_src1_en && m_vec[in_src1]);
  endfunction

  task automatic set_in(input bit v, input bit miss, input bit s0e, input int s0,
                        input bit s1e, input int s1, input bit de, input int d);
    in_valid = v; in_miss = miss; in_src0_en = s0e; in_src0 = 5'(s0);
    in_src1_en = s1e; in_src1 = 5'(s1); in_dst_en = de; in_dst = 5'(d);
    in_tag = TAG_W'(ntag);
  endtask

  task automatic step(input string ov);
    bit slow, rdy, match;
    logic [LANES-1:0] ev;
    int npop;
    string lr, lm, lv;
    @(negedge clk); #1;
    slow = m_slow();
    rdy  = slow ? (m_cnt < DEPTH) : main_ready;
    ev[0] = (m_cnt > 0) && (!m_ld[m_head] || m_rel);
    for (int k = 1; k < LANES; k++)
      ev[k] = ev[k-1] && (m_cnt > k) && !m_ld[(m_head + k) % DEPTH];
    lr = (ov != "") ? ov : (slow ? "R5" : "R10");
    lm = (ov != "") ? ov : (in_miss ? "R2" : (slow ? "R3" : "R4"));
    lv = (ov != "") ? ov : (reins_ready ? "R7" : "R8");
    chk(in_ready === rdy, lr, "in_ready", int'(in_ready), int'(rdy));
    chk(main_valid === (in_valid && !slow), lm, "main_valid", int'(main_valid), int'(in_valid && !slow));
    if (in_valid && !slow)
      chk(main_tag === in_tag, lm, "main_tag", int'(main_tag), int'(in_tag));
    chk(reins_valid === ev, lv, "reins_valid", int'(reins_valid), int'(ev));
    for (int k = 0; k < LANES; k++)
      if (ev[k])
        chk(reins_tag[k*TAG_W +: TAG_W] === m_tag[(m_head + k) % DEPTH], lv, "reins_tag",
            int'(reins_tag[k*TAG_W +: TAG_W]), int'(m_tag[(m_head + k) % DEPTH]));
    @(posedge clk);
    npop  = reins_ready ? $countones(ev) : 0;
    match = cpl_valid && (m_cnt > 0) && m_ld[m_head] && (m_tag[m_head] == cpl_tag);
    m_rel = (npop > 0) ? 1'b0 : (m_rel || match);
    m_head = (m_head + npop) % DEPTH;
    m_cnt  = m_cnt - npop;
    if (in_valid && rdy) begin
      if (slow) begin
        m_tag[(m_head + m_cnt) % DEPTH] = in_tag;
        m_ld[(m_head + m_cnt) % DEPTH]  = in_miss;
        m_cnt++;
      end
      if (in_dst_en) m_vec[in_dst] = slow;
      ntag++;
    end
    if (m_cnt == 0) m_vec = '0;
    #1;
  endtask

  task automatic idle();
    set_in(0, 0, 0, 0, 0, 0, 0, 0);
    cpl_valid = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state
    step("R1");
    // R2: miss load to slow queue, dst r3
    set_in(1, 1, 0, 0, 0, 0, 1, 3); step("R2");
    // R3: dependents chain r3 -> r4, then reads of r4
    set_in(1, 0, 1, 3, 0, 0, 1, 4); step("R3");
    for (int i = 0; i < 5; i++) begin
      set_in(1, 0, 0, 0, 1, 4, 1, 5); step("R3");
    end
    // R4: independent instruction goes main
    set_in(1, 0, 1, 9, 1, 10, 1, 11); step("R4");
    idle();
    // R6: wrong completion tag has no effect
    cpl_valid = 1; cpl_tag = m_tag[m_head] + 1'b1; step("R6");
    cpl_valid = 0; step("R6");
    // R6: matching completion, lanes show next cycle; R8 hold while not ready
    cpl_valid = 1; cpl_tag = m_tag[m_head]; step("R6");
    cpl_valid = 0; step("R8"); step("R8");
    // R7: drain four then three
    reins_ready = 1; step("R7"); step("R7");
    reins_ready = 0;
    // R9: queue empty, r4 unmarked -> main
    set_in(1, 0, 1, 4, 0, 0, 1, 6); step("R9");
    // R10: main-bound held by main_ready
    main_ready = 0; set_in(1, 0, 1, 4, 0, 0, 1, 6); step("R10");
    main_ready = 1;
    // R5: fill the slow queue past capacity
    for (int i = 0; i < 70; i++) begin
      set_in(1, 1, 0, 0, 0, 0, 1, i % 32); step("");
    end
    idle(); reins_ready = 1;
    for (int i = 0; i < 200 && m_cnt > 0; i++) begin
      cpl_valid = (m_cnt > 0) && m_ld[m_head] && !m_rel;
      cpl_tag = m_tag[m_head];
      step("");
    end
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      set_in(($urandom % 10) < 7, ($urandom % 100) < 15, $urandom % 2, $urandom % 8,
             $urandom % 2, $urandom % 8, ($urandom % 10) < 8, $urandom % 8);
      main_ready  = ($urandom % 10) < 8;
      reins_ready = ($urandom % 10) < 7;
      cpl_valid   = ($urandom % 10) < 3;
      cpl_tag     = (($urandom % 10) < 7 && m_cnt > 0) ? m_tag[m_head] : TAG_W'($urandom % 64);
      step("");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule